// File: doc/BRIEF.md
# Multi-Cycle Processor Sequencer

This block is the control sequencer for a multi-cycle processor datapath. That datapath has one shared memory, one ALU, and holding registers between steps. The sequencer breaks each instruction into a few one-clock steps. In every step it drives a fixed set of datapath strobes and selector codes, and it picks the step that comes next.

Every instruction starts with the same two steps. The first fetches the instruction and advances the PC. The second reads the register operands, and in the same cycle it computes a branch target ahead of time, before the instruction class is known. After that the sequencer follows a class-specific path and returns to fetch. A jump or a branch takes 3 cycles, a store or a register-register operation takes 4, and a load takes 5.

Two cases leave the normal paths through an exception step. The first is an opcode outside the supported set. The second is an arithmetic overflow reported while a register-register operation executes. The exception step saves the return address, records the cause and loads the handler entry address into the PC. The opcode is only looked at in the decode step. The overflow flag is only looked at in the register-register execute step.

Top module: `mc_ctrl`

## Requirements
- R1: While `rst_n` is low, and for two clock edges after it rises, the block sits in the fetch step. The first step change happens on the third rising edge after release.
- R2: The fetch step asserts `mem_rd`, `ir_wr` and `pc_wr`. It drives `addr_sel`=0 (PC), `alu_a_sel`=0 (PC), `alu_b_sel`=01 (constant 4), `alu_op`=00 (add) and `pc_src`=00 (ALU result). All other outputs are 0. Fetch is always followed by decode.
- R3: The decode step drives only `alu_a_sel`=0, `alu_b_sel`=11 (immediate shifted left by 2) and `alu_op`=00. All strobes are low.
- R4: Opcode 100011 (load) runs fetch, decode, address, read, writeback, then fetch.
  - The address step drives `alu_a_sel`=1 (A), `alu_b_sel`=10 (sign-extended immediate) and `alu_op`=00.
  - The read step drives `mem_rd`, `mdr_wr` and `addr_sel`=1 (ALUOut).
  - The writeback step drives `reg_wr`, `reg_dst`=0 (rt) and `wb_sel`=1 (MDR).
- R5: Opcode 101011 (store) runs fetch, decode, address, then a write step with `mem_wr` and `addr_sel`=1, then fetch.
- R6: Opcode 000000 (register-register) runs fetch, decode, then execute, then writeback, then fetch.
  - Execute drives `alu_a_sel`=1, `alu_b_sel`=00 (B) and `alu_op`=10 (function field).
  - Writeback drives `reg_wr`, `reg_dst`=1 (rd) and `wb_sel`=0 (ALUOut).
- R7: Opcode 000100 (branch on equal) runs fetch, decode, then a compare step, then fetch. The compare step drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01 (subtract), `pc_wr_cond`=1, `pc_src`=01 (ALUOut) and `pc_wr`=0.
- R8: Opcode 000010 (jump) runs fetch, decode, then a step with `pc_wr`=1 and `pc_src`=10 (jump target), then fetch.
- R9: Any other opcode runs fetch, decode, then an exception step, then fetch. The exception step drives:
  - `epc_wr`, `cause_wr` and `pc_wr`, with `cause_code`=0;
  - `pc_src`=11 (exception vector);
  - `alu_a_sel`=0, `alu_b_sel`=01 and `alu_op`=01.
- R10: If `alu_ovf` is high in the register-register execute step, the next step is an exception step. It is the R9 step with `cause_code`=1, and then the block returns to fetch. The register writeback step is skipped.
- R11: `alu_ovf` has no effect in any step other than register-register execute.
- R12: The opcode has no effect in any step other than decode. The outputs depend on the current step only.
- R13: `mem_rd` and `mem_wr` are never high together. `pc_wr` and `pc_wr_cond` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_ovf | input | 1 | ALU signed overflow flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALUOut |
| ir_wr | output | 1 | Instruction register load |
| mdr_wr | output | 1 | Memory data register load |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination register: 0 rt, 1 rd |
| wb_sel | output | 1 | Writeback data: 0 ALUOut, 1 MDR |
| alu_a_sel | output | 1 | ALU input A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU input B: 00 B, 01 four, 10 immediate, 11 immediate shifted by 2 |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 function field |
| pc_wr | output | 1 | Unconditional PC load |
| pc_wr_cond | output | 1 | PC load when the ALU result is zero |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALUOut, 10 jump target, 11 exception vector |
| epc_wr | output | 1 | Exception PC register load |
| cause_wr | output | 1 | Cause register load |
| cause_code | output | 1 | Cause value: 0 undefined opcode, 1 overflow |

## Verification
Each supported opcode is run through its whole path, and every step's control word is compared with the word expected for that step. This shows whether each class takes the right number of cycles and the right strobes. An unsupported opcode, and a register-register instruction with overflow raised during execute, check that the two exception exits are taken and carry different cause codes. In noisy runs the opcode is set to a wrong value outside decode and the overflow flag is toggled outside execute. These runs show that each input is sampled in exactly one step and nowhere else.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_RTYPE  = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP   = 6'b000010;

  // ALU B operand selector
  localparam logic [1:0] BSEL_REG  = 2'b00;
  localparam logic [1:0] BSEL_FOUR = 2'b01;
  localparam logic [1:0] BSEL_IMM  = 2'b10;
  localparam logic [1:0] BSEL_IMM4 = 2'b11;

  // ALU operation
  localparam logic [1:0] AOP_ADD   = 2'b00;
  localparam logic [1:0] AOP_SUB   = 2'b01;
  localparam logic [1:0] AOP_FUNCT = 2'b10;

  // PC source selector
  localparam logic [1:0] PSRC_ALU  = 2'b00;
  localparam logic [1:0] PSRC_OUT  = 2'b01;
  localparam logic [1:0] PSRC_JMP  = 2'b10;
  localparam logic [1:0] PSRC_VEC  = 2'b11;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_ADDR_LD,
    ST_ADDR_ST,
    ST_MEM_RD,
    ST_LD_WB,
    ST_MEM_WR,
    ST_R_EXEC,
    ST_R_WB,
    ST_BRANCH,
    ST_JUMP,
    ST_EXC_UND,
    ST_EXC_OVF
  } state_e;

  typedef enum logic [2:0] {
    IC_RTYPE,
    IC_LOAD,
    IC_STORE,
    IC_BRANCH,
    IC_JUMP,
    IC_UNDEF
  } iclass_e;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       ir_wr;
    logic       mdr_wr;
    logic       reg_wr;
    logic       reg_dst;
    logic       wb_sel;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic       pc_wr;
    logic       pc_wr_cond;
    logic [1:0] pc_src;
    logic       epc_wr;
    logic       cause_wr;
    logic       cause_code;
  } ctrl_t;

endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/mc_op_decode.sv
module mc_op_decode
  import mc_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output iclass_e          iclass
);

  always_comb begin
    case (opcode)
      OPC_RTYPE:  iclass = IC_RTYPE;
      OPC_LOAD:   iclass = IC_LOAD;
      OPC_STORE:  iclass = IC_STORE;
      OPC_BRANCH: iclass = IC_BRANCH;
      OPC_JUMP:   iclass = IC_JUMP;
      default:    iclass = IC_UNDEF;
    endcase
  end

endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  state_e  state_q,
  input  iclass_e iclass,
  input  logic    alu_ovf,
  output state_e  state_d
);

  always_comb begin
    state_d = ST_FETCH;
    case (state_q)
      ST_FETCH: state_d = ST_DECODE;
      ST_DECODE: begin
        case (iclass)
          IC_RTYPE:  state_d = ST_R_EXEC;
          IC_LOAD:   state_d = ST_ADDR_LD;
          IC_STORE:  state_d = ST_ADDR_ST;
          IC_BRANCH: state_d = ST_BRANCH;
          IC_JUMP:   state_d = ST_JUMP;
          default:   state_d = ST_EXC_UND;
        endcase
      end
      ST_ADDR_LD: state_d = ST_MEM_RD;
      ST_ADDR_ST: state_d = ST_MEM_WR;
      ST_MEM_RD:  state_d = ST_LD_WB;
      ST_R_EXEC:  state_d = alu_ovf ? ST_EXC_OVF : ST_R_WB;
      default:    state_d = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_word.sv
module mc_ctrl_word
  import mc_ctrl_pkg::*;
(
  input  state_e state_q,
  output ctrl_t  cw
);

  always_comb begin
    cw = '0;
    case (state_q)
      ST_FETCH: begin
        cw.mem_rd    = 1'b1;
        cw.ir_wr     = 1'b1;
        cw.alu_b_sel = BSEL_FOUR;
        cw.alu_op    = AOP_ADD;
        cw.pc_wr     = 1'b1;
        cw.pc_src    = PSRC_ALU;
      end
      ST_DECODE: begin
        cw.alu_b_sel = BSEL_IMM4;
        cw.alu_op    = AOP_ADD;
      end
      ST_ADDR_LD, ST_ADDR_ST: begin
        cw.alu_a_sel = 1'b1;
        cw.alu_b_sel = BSEL_IMM;
        cw.alu_op    = AOP_ADD;
      end
      ST_MEM_RD: begin
        cw.mem_rd   = 1'b1;
        cw.addr_sel = 1'b1;
        cw.mdr_wr   = 1'b1;
      end
      ST_LD_WB: begin
        cw.reg_wr  = 1'b1;
        cw.wb_sel  = 1'b1;
      end
      ST_MEM_WR: begin
        cw.mem_wr   = 1'b1;
        cw.addr_sel = 1'b1;
      end
      ST_R_EXEC: begin
        cw.alu_a_sel = 1'b1;
        cw.alu_b_sel = BSEL_REG;
        cw.alu_op    = AOP_FUNCT;
      end
      ST_R_WB: begin
        cw.reg_wr  = 1'b1;
        cw.reg_dst = 1'b1;
      end
      ST_BRANCH: begin
        cw.alu_a_sel  = 1'b1;
        cw.alu_b_sel  = BSEL_REG;
        cw.alu_op     = AOP_SUB;
        cw.pc_wr_cond = 1'b1;
        cw.pc_src     = PSRC_OUT;
      end
      ST_JUMP: begin
        cw.pc_wr  = 1'b1;
        cw.pc_src = PSRC_JMP;
      end
      ST_EXC_UND, ST_EXC_OVF: begin
        cw.alu_b_sel  = BSEL_FOUR;
        cw.alu_op     = AOP_SUB;
        cw.pc_wr      = 1'b1;
        cw.pc_src     = PSRC_VEC;
        cw.epc_wr     = 1'b1;
        cw.cause_wr   = 1'b1;
        cw.cause_code = (state_q == ST_EXC_OVF);
      end
      default: cw = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_ovf,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             addr_sel,
  output logic             ir_wr,
  output logic             mdr_wr,
  output logic             reg_wr,
  output logic             reg_dst,
  output logic             wb_sel,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_op,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic [1:0]       pc_src,
  output logic             epc_wr,
  output logic             cause_wr,
  output logic             cause_code
);

  logic    rst_n_sync;
  state_e  state_q;
  state_e  state_d;
  iclass_e iclass;
  ctrl_t   cw;

  mc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  mc_op_decode u_op_decode (
    .opcode (opcode),
    .iclass (iclass)
  );

  mc_next_state u_next_state (
    .state_q (state_q),
    .iclass  (iclass),
    .alu_ovf (alu_ovf),
    .state_d (state_d)
  );

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      state_q <= ST_FETCH;
    end else begin
      state_q <= state_d;
    end
  end

  mc_ctrl_word u_ctrl_word (
    .state_q (state_q),
    .cw      (cw)
  );

  assign mem_rd     = cw.mem_rd;
  assign mem_wr     = cw.mem_wr;
  assign addr_sel   = cw.addr_sel;
  assign ir_wr      = cw.ir_wr;
  assign mdr_wr     = cw.mdr_wr;
  assign reg_wr     = cw.reg_wr;
  assign reg_dst    = cw.reg_dst;
  assign wb_sel     = cw.wb_sel;
  assign alu_a_sel  = cw.alu_a_sel;
  assign alu_b_sel  = cw.alu_b_sel;
  assign alu_op     = cw.alu_op;
  assign pc_wr      = cw.pc_wr;
  assign pc_wr_cond = cw.pc_wr_cond;
  assign pc_src     = cw.pc_src;
  assign epc_wr     = cw.epc_wr;
  assign cause_wr   = cw.cause_wr;
  assign cause_code = cw.cause_code;

endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk
  import mc_ctrl_pkg::*;
(
  input logic    clk,
  input logic    rst_n_sync,
  input state_e  state_q,
  input iclass_e iclass,
  input logic    alu_ovf,
  input logic    mem_rd,
  input logic    mem_wr,
  input logic    pc_wr,
  input logic    pc_wr_cond,
  input logic    reg_wr
);

  p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    state_q == ST_FETCH |=> state_q == ST_DECODE);

  p_load_read_then_wb_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    state_q == ST_MEM_RD |=> state_q == ST_LD_WB);

  p_branch_returns_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    state_q == ST_BRANCH |=> state_q == ST_FETCH);

  p_undef_exit_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (state_q == ST_DECODE && iclass == IC_UNDEF) |=> state_q == ST_EXC_UND);

  p_ovf_exit_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (state_q == ST_R_EXEC && alu_ovf) |=> (state_q == ST_EXC_OVF && !reg_wr));

  p_ovf_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (state_q == ST_ADDR_LD && alu_ovf) |=> state_q == ST_MEM_RD);

  p_mem_excl_r13: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(mem_rd && mem_wr));

  p_pc_excl_r13: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(pc_wr && pc_wr_cond));

endmodule

bind mc_ctrl mc_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .state_q    (state_q),
  .iclass     (iclass),
  .alu_ovf    (alu_ovf),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .pc_wr      (pc_wr),
  .pc_wr_cond (pc_wr_cond),
  .reg_wr     (reg_wr)
);

// File: tb/test_mc_ctrl.sv
module test_mc_ctrl;

  localparam int CLK_PERIOD = 10;

  localparam int S_F  = 0;
  localparam int S_D  = 1;
  localparam int S_MA = 2;
  localparam int S_MR = 3;
  localparam int S_LW = 4;
  localparam int S_MW = 5;
  localparam int S_RX = 6;
  localparam int S_RW = 7;
  localparam int S_BR = 8;
  localparam int S_J  = 9;
  localparam int S_XU = 10;
  localparam int S_XO = 11;

  logic       clk;
  logic       rst_n;
  logic [5:0] opcode;
  logic       alu_ovf;
  logic mem_rd, mem_wr, addr_sel, ir_wr, mdr_wr, reg_wr, reg_dst, wb_sel, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  logic pc_wr, pc_wr_cond, epc_wr, cause_wr, cause_code;

  int checks;
  int failures;
  bit done;

  mc_ctrl i_mc_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_ovf(alu_ovf),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_wr(ir_wr),
    .mdr_wr(mdr_wr), .reg_wr(reg_wr), .reg_dst(reg_dst), .wb_sel(wb_sel),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src),
    .epc_wr(epc_wr), .cause_wr(cause_wr), .cause_code(cause_code)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // order: mem_rd mem_wr addr_sel ir_wr mdr_wr reg_wr reg_dst wb_sel alu_a_sel
  //        alu_b_sel alu_op pc_wr pc_wr_cond pc_src epc_wr cause_wr cause_code
  function automatic logic [19:0] exp_word(input int s);
    case (s)
      S_F:  return {9'b1_0_0_1_0_0_0_0_0, 2'b01, 2'b00, 2'b10, 2'b00, 3'b000};
      S_D:  return {9'b0_0_0_0_0_0_0_0_0, 2'b11, 2'b00, 2'b00, 2'b00, 3'b000};
      S_MA: return {9'b0_0_0_0_0_0_0_0_1, 2'b10, 2'b00, 2'b00, 2'b00, 3'b000};
      S_MR: return {9'b1_0_1_0_1_0_0_0_0, 2'b00, 2'b00, 2'b00, 2'b00, 3'b000};
      S_LW: return {9'b0_0_0_0_0_1_0_1_0, 2'b00, 2'b00, 2'b00, 2'b00, 3'b000};
      S_MW: return {9'b0_1_1_0_0_0_0_0_0, 2'b00, 2'b00, 2'b00, 2'b00, 3'b000};
      S_RX: return {9'b0_0_0_0_0_0_0_0_1, 2'b00, 2'b10, 2'b00, 2'b00, 3'b000};
      S_RW: return {9'b0_0_0_0_0_1_1_0_0, 2'b00, 2'b00, 2'b00, 2'b00, 3'b000};
      S_BR: return {9'b0_0_0_0_0_0_0_0_1, 2'b00, 2'b01, 2'b01, 2'b01, 3'b000};
      S_J:  return {9'b0_0_0_0_0_0_0_0_0, 2'b00, 2'b00, 2'b10, 2'b10, 3'b000};
      S_XU: return {9'b0_0_0_0_0_0_0_0_0, 2'b01, 2'b01, 2'b10, 2'b11, 3'b110};
      S_XO: return {9'b0_0_0_0_0_0_0_0_0, 2'b01, 2'b01, 2'b10, 2'b11, 3'b111};
      default: return '0;
    endcase
  endfunction

  function automatic logic [19:0] act_word();
    return {mem_rd, mem_wr, addr_sel, ir_wr, mdr_wr, reg_wr, reg_dst, wb_sel,
            alu_a_sel, alu_b_sel, alu_op, pc_wr, pc_wr_cond, pc_src,
            epc_wr, cause_wr, cause_code};
  endfunction

  task automatic check_word(input string tag, input int step, input int s);
    checks++;
    if (act_word() !== exp_word(s)) begin
      failures++;
      $display("FAIL %s step %0d: actual %b expected %b", tag, step, act_word(), exp_word(s));
    end
    checks++;
    if ((mem_rd && mem_wr) || (pc_wr && pc_wr_cond)) begin
      failures++;
      $display("FAIL R13 step %0d: actual rd/wr=%b%b pcw/cond=%b%b expected no pair high",
               step, mem_rd, mem_wr, pc_wr, pc_wr_cond);
    end
  endtask

  // Runs one instruction from fetch. Called at a negedge with the block in fetch.
  task automatic run_instr(input string tag, input logic [5:0] op, input logic ovf_exec,
                           input logic noisy, input int n,
                           input int s0, input int s1, input int s2, input int s3, input int s4);
    int seq [5];
    seq = '{s0, s1, s2, s3, s4};
    for (int i = 0; i < n; i++) begin
      opcode  = (noisy && i != 1) ? ~op : op;
      alu_ovf = (seq[i] == S_RX) ? ovf_exec : noisy;
      check_word(tag, i, seq[i]);
      @(posedge clk);
      @(negedge clk);
    end
    opcode  = op;
    alu_ovf = 1'b0;
    check_word({tag, " return-to-fetch"}, n, S_F);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    opcode = 6'b000010;
    alu_ovf = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_word("R1 in reset", 0, S_F);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_word("R1 sync release", 1, S_F);
    @(posedge clk);
    @(negedge clk);
    check_word("R1 first advance", 2, S_D);
    // finish the jump so the block is back in fetch
    @(posedge clk);
    @(negedge clk);
    check_word("R8 after reset", 3, S_J);
    @(posedge clk);
    @(negedge clk);
    check_word("R2 fetch", 4, S_F);
  endtask

  task automatic t_load();   run_instr("R4 load",  6'b100011, 1'b0, 1'b0, 5, S_F, S_D, S_MA, S_MR, S_LW); endtask
  task automatic t_store();  run_instr("R5 store", 6'b101011, 1'b0, 1'b0, 4, S_F, S_D, S_MA, S_MW, S_F); endtask
  task automatic t_rtype();  run_instr("R6 rtype", 6'b000000, 1'b0, 1'b0, 4, S_F, S_D, S_RX, S_RW, S_F); endtask
  task automatic t_branch(); run_instr("R7 beq",   6'b000100, 1'b0, 1'b0, 3, S_F, S_D, S_BR, S_F, S_F); endtask
  task automatic t_jump();   run_instr("R8 jump",  6'b000010, 1'b0, 1'b0, 3, S_F, S_D, S_J, S_F, S_F); endtask
  task automatic t_undef();
    run_instr("R9 undef 111111", 6'b111111, 1'b0, 1'b0, 3, S_F, S_D, S_XU, S_F, S_F);
    run_instr("R9 undef 100001", 6'b100001, 1'b0, 1'b0, 3, S_F, S_D, S_XU, S_F, S_F);
  endtask
  task automatic t_overflow(); run_instr("R10 ovf", 6'b000000, 1'b1, 1'b0, 4, S_F, S_D, S_RX, S_XO, S_F); endtask
  task automatic t_noise();
    run_instr("R11 R12 noisy load",  6'b100011, 1'b0, 1'b1, 5, S_F, S_D, S_MA, S_MR, S_LW);
    run_instr("R11 R12 noisy store", 6'b101011, 1'b0, 1'b1, 4, S_F, S_D, S_MA, S_MW, S_F);
    run_instr("R11 R12 noisy rtype", 6'b000000, 1'b0, 1'b1, 4, S_F, S_D, S_RX, S_RW, S_F);
    run_instr("R11 R12 noisy beq",   6'b000100, 1'b0, 1'b1, 3, S_F, S_D, S_BR, S_F, S_F);
  endtask
  task automatic t_decode_only();
    // R3: decode word, opcode changes within a step leave the word alone (R12)
    opcode = 6'b100011;
    @(posedge clk);
    @(negedge clk);
    check_word("R3 decode", 0, S_D);
    opcode = 6'b000010;
    #1;
    check_word("R12 moore", 1, S_D);
    opcode = 6'b000100;
    @(posedge clk);
    @(negedge clk);
    check_word("R7 from decode", 2, S_BR);
    @(posedge clk);
    @(negedge clk);
    check_word("R7 back", 3, S_F);
  endtask

  initial begin
    checks = 0;
    failures = 0;
    done = 1'b0;
    t_reset();
    t_load();
    t_store();
    t_rtype();
    t_branch();
    t_jump();
    t_undef();
    t_overflow();
    t_noise();
    t_decode_only();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule